// File: doc/BRIEF.md
# Interrupt Moderation Controller for a Network Interface

This block sits between the receive and transmit engines of a network controller and the host interrupt line. It collects interrupt causes, holds them in a pending register, and decides when the host is told. Four coalescing delay timers turn a burst of completed descriptors into one event. Two timers serve the receive ring: a per-packet delay that each new arm restarts, and an absolute delay that runs to the end once armed. Two serve the transmit ring: an absolute delay and an idle delay that each new arm restarts. When a timer expires, it asks for a descriptor write-back on its ring and posts that ring's timer cause.

A throttle timer sets a minimum quiet interval after each cause-register read. Causes posted during that interval stay pending and reach the line once the interval ends. A per-post immediate flag bypasses the throttle. A mask write re-evaluates the pending causes at once, so the line can rise or fall without a new cause arriving. All timers count in ticks of `TICK_CYCLES` clocks, where one tick stands for 1024 ns (128 cycles at 125 MHz). The register decoder outside the block supplies the strobes and reads `cause_o`.

Top module: `irq_moderator`

## Requirements
- R1: The receive packet delay timer (load bit 0, arm bit 0) armed with a non-zero value V pulses `rx_wb_o` for one cycle V*TICK_CYCLES cycles after the arm edge. The cause bit RXT_BIT (7) is set one cycle later. A new arm while it runs restarts the count.
- R2: The receive absolute delay timer (load bit 1, arm bit 1) acts as in R1 on expiry, but ignores an arm while it is already running.
- R3: The transmit absolute timer (bit 2, arm ignored while running) and the transmit idle timer (bit 3, arm restarts) each pulse `tx_wb_o` on expiry and set cause bit TXDW_BIT (0) one cycle later.
- R4: A posted cause sets its bit in `cause_o` whatever the mask says. `irq_o` is high only while some pending bit has its mask bit set (mask bit 1 = enabled).
- R5: A mask write takes effect at the next edge. It raises `irq_o` if an enabled cause is pending and the throttle is idle, and it drops `irq_o` if no enabled cause remains.
- R6: After a cause read with throttle value N (load bit 4) non-zero, a non-immediate post leaves `irq_o` low for N*TICK_CYCLES cycles after the read edge. `irq_o` rises one cycle after that if the cause is still enabled.
- R7: A post with `imm_i` high and an enabled cause raises `irq_o` at the next edge, even while the throttle runs.
- R8: A cause read (`clr_rd_i`) clears `cause_o` and drops `irq_o` at the next edge and restarts the throttle. Causes posted in that same cycle survive.
- R9: A timer whose value is zero never starts, never pulses a write-back and posts no cause.
- R10: After reset, `irq_o`, `cause_o`, both write-back pulses, the mask and all timer values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_i | input | NCAUSE | One-cycle cause pulses from the data paths |
| imm_i | input | 1 | Posts in this cycle bypass the throttle |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_val_i | input | NCAUSE | New mask value, 1 = cause enabled |
| clr_rd_i | input | 1 | Cause register read strobe (clear on read) |
| tmr_val_i | input | TW | Value for a timer load, in ticks |
| tmr_load_i | input | 5 | Load strobes: 0 rx packet, 1 rx absolute, 2 tx absolute, 3 tx idle, 4 throttle |
| tmr_arm_i | input | 4 | Arm strobes for the four delay timers, same bit order |
| irq_o | output | 1 | Interrupt line to the host |
| cause_o | output | NCAUSE | Pending cause register |
| rx_wb_o | output | 1 | Receive descriptor write-back request pulse |
| tx_wb_o | output | 1 | Transmit descriptor write-back request pulse |

## Verification
The hardest case to reach from the ports is a cause that the throttle holds back and then releases. It needs a non-zero throttle value, a cause read to start the interval, and a post that lands inside the window. The stimulus loads the throttle, issues the read, posts a cause two cycles later, and expects the line low on the last cycle of the interval and high on the cycle after. The restart-versus-absolute difference is reached by re-arming each timer a few cycles after its first arm. The stimulus then checks that the pulse moves for the restarting timers and stays put for the absolute ones.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NDELAY   = 4;
  localparam int NTMR_ALL = 5;
  localparam int T_RXPKT  = 0;
  localparam int T_RXABS  = 1;
  localparam int T_TXABS  = 2;
  localparam int T_TXIDL  = 3;
  localparam int T_THR    = 4;

  // Timers whose arm strobe restarts a running count
  function automatic bit rearms(int idx);
    return (idx == T_RXPKT) || (idx == T_TXIDL);
  endfunction

  // Next value of the interrupt line
  function automatic logic line_next(logic enabled_any, logic imm_post,
                                     logic clr, logic line_q, logic thr_busy);
    if (!enabled_any)   return 1'b0;
    else if (imm_post)  return 1'b1;
    else if (clr)       return 1'b0;
    else if (line_q)    return 1'b1;
    else                return !thr_busy;
  endfunction
endpackage

// File: rtl/irqm_timer.sv
module irqm_timer #(
  parameter int TW          = 16,
  parameter int TICK_CYCLES = 128,
  parameter int RESTART     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          arm_i,
  output logic          busy_o,
  output logic          expire_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(TICK_CYCLES - 1);

  logic [TW-1:0] val_q, tcnt_q, val_eff;
  logic [PW-1:0] pcnt_q;
  logic          busy_q, expire_q;
  logic          start_w, tick_w, last_w;

  assign val_eff = load_i ? val_i : val_q;
  assign start_w = arm_i && (val_eff != '0) && ((RESTART != 0) || !busy_q);
  assign tick_w  = busy_q && (pcnt_q == '0);
  assign last_w  = tick_w && (tcnt_q == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q    <= '0;
      tcnt_q   <= '0;
      pcnt_q   <= '0;
      busy_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      if (load_i) val_q <= val_i;
      expire_q <= last_w && !start_w;
      if (start_w) begin
        busy_q <= 1'b1;
        tcnt_q <= val_eff;
        pcnt_q <= PRE_TOP;
      end else if (busy_q) begin
        if (tick_w) begin
          pcnt_q <= PRE_TOP;
          if (last_w) busy_q <= 1'b0;
          else        tcnt_q <= tcnt_q - TW'(1);
        end else begin
          pcnt_q <= pcnt_q - PW'(1);
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/irqm_cause.sv
module irqm_cause import irqm_pkg::*; #(
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] post_i,
  input  logic          imm_i,
  input  logic          mask_wr_i,
  input  logic [NC-1:0] mask_val_i,
  input  logic          clr_i,
  input  logic          thr_busy_i,
  output logic [NC-1:0] pend_o,
  output logic [NC-1:0] mask_o,
  output logic          line_o
);
  logic [NC-1:0] pend_q, pend_n, mask_q, mask_n;
  logic          line_q, line_n;
  logic          enabled_any, imm_post;

  assign pend_n      = (clr_i ? '0 : pend_q) | post_i;
  assign mask_n      = mask_wr_i ? mask_val_i : mask_q;
  assign enabled_any = |(pend_n & mask_n);
  assign imm_post    = imm_i && (|(post_i & mask_n));
  assign line_n      = line_next(enabled_any, imm_post, clr_i, line_q, thr_busy_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      line_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      mask_q <= mask_n;
      line_q <= line_n;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign line_o = line_q;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator import irqm_pkg::*; #(
  parameter int NCAUSE      = 8,
  parameter int TW          = 16,
  parameter int TICK_CYCLES = 128,
  parameter int RXT_BIT     = 7,
  parameter int TXDW_BIT    = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCAUSE-1:0]   cause_i,
  input  logic                imm_i,
  input  logic                mask_wr_i,
  input  logic [NCAUSE-1:0]   mask_val_i,
  input  logic                clr_rd_i,
  input  logic [TW-1:0]       tmr_val_i,
  input  logic [NTMR_ALL-1:0] tmr_load_i,
  input  logic [NDELAY-1:0]   tmr_arm_i,
  output logic                irq_o,
  output logic [NCAUSE-1:0]   cause_o,
  output logic                rx_wb_o,
  output logic                tx_wb_o
);
  function automatic logic [NCAUSE-1:0] timer_causes(logic rx, logic tx);
    logic [NCAUSE-1:0] v;
    v           = '0;
    v[RXT_BIT]  = rx;
    v[TXDW_BIT] = tx;
    return v;
  endfunction

  logic [NDELAY-1:0] dly_expire, dly_busy;
  logic              thr_busy, thr_expire;
  logic [NCAUSE-1:0] post_vec, mask_q;

  for (genvar g = 0; g < NDELAY; g++) begin : g_dly
    irqm_timer #(
      .TW(TW), .TICK_CYCLES(TICK_CYCLES), .RESTART(rearms(g) ? 1 : 0)
    ) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .load_i(tmr_load_i[g]), .val_i(tmr_val_i), .arm_i(tmr_arm_i[g]),
      .busy_o(dly_busy[g]), .expire_o(dly_expire[g])
    );
  end

  irqm_timer #(.TW(TW), .TICK_CYCLES(TICK_CYCLES), .RESTART(1)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load_i[T_THR]), .val_i(tmr_val_i), .arm_i(clr_rd_i),
    .busy_o(thr_busy), .expire_o(thr_expire)
  );

  assign rx_wb_o  = dly_expire[T_RXPKT] | dly_expire[T_RXABS];
  assign tx_wb_o  = dly_expire[T_TXABS] | dly_expire[T_TXIDL];
  assign post_vec = cause_i | timer_causes(rx_wb_o, tx_wb_o);

  irqm_cause #(.NC(NCAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .post_i(post_vec), .imm_i(imm_i),
    .mask_wr_i(mask_wr_i), .mask_val_i(mask_val_i),
    .clr_i(clr_rd_i), .thr_busy_i(thr_busy),
    .pend_o(cause_o), .mask_o(mask_q), .line_o(irq_o)
  );

  logic unused_ok;
  assign unused_ok = ^{dly_busy, thr_expire};
endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
  parameter int NC       = 8,
  parameter int RXT_BIT  = 7,
  parameter int TXDW_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic [NC-1:0] cause_o,
  input logic [NC-1:0] mask_q,
  input logic          rx_wb_o,
  input logic          tx_wb_o,
  input logic          clr_rd_i,
  input logic          imm_i,
  input logic          thr_busy
);
  p_rx_post_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_o |=> cause_o[RXT_BIT]);

  p_tx_post_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_o |=> cause_o[TXDW_BIT]);

  p_line_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(cause_o & mask_q)));

  p_throttle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && thr_busy && !imm_i) |=> !irq_o);

  p_clear_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd_i && !imm_i) |=> !irq_o);
endmodule

bind irq_moderator irqm_checker #(
  .NC(NCAUSE), .RXT_BIT(RXT_BIT), .TXDW_BIT(TXDW_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .cause_o(cause_o),
  .mask_q(mask_q), .rx_wb_o(rx_wb_o), .tx_wb_o(tx_wb_o),
  .clr_rd_i(clr_rd_i), .imm_i(imm_i), .thr_busy(thr_busy)
);

// File: tb/tb_irq_moderator.sv
module tb_irq_moderator;
  localparam int NC = 8;
  localparam int TW = 16;
  localparam int TK = 4;
  localparam int S_IRQ = 0, S_CAUSE = 1, S_RXWB = 2, S_TXWB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cause_i = '0;
  logic          imm_i = 1'b0;
  logic          mask_wr_i = 1'b0;
  logic [NC-1:0] mask_val_i = '0;
  logic          clr_rd_i = 1'b0;
  logic [TW-1:0] tmr_val_i = '0;
  logic [4:0]    tmr_load_i = '0;
  logic [3:0]    tmr_arm_i = '0;
  logic          irq_o, rx_wb_o, tx_wb_o;
  logic [NC-1:0] cause_o;

  always #4 clk = ~clk;

  irq_moderator #(.NCAUSE(NC), .TW(TW), .TICK_CYCLES(TK)) dut (
    .clk(clk), .rst_n(rst_n), .cause_i(cause_i), .imm_i(imm_i),
    .mask_wr_i(mask_wr_i), .mask_val_i(mask_val_i), .clr_rd_i(clr_rd_i),
    .tmr_val_i(tmr_val_i), .tmr_load_i(tmr_load_i), .tmr_arm_i(tmr_arm_i),
    .irq_o(irq_o), .cause_o(cause_o), .rx_wb_o(rx_wb_o), .tx_wb_o(tx_wb_o)
  );

  typedef struct { int cyc; int sig; int exp; string req; } item_t;
  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, int sig, int exp, string req);
    item_t it;
    it.cyc = c; it.sig = sig; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  function automatic int observe(int sig);
    case (sig)
      S_IRQ:   return int'(irq_o);
      S_CAUSE: return int'(cause_o);
      S_RXWB:  return int'(rx_wb_o);
      default: return int'(tx_wb_o);
    endcase
  endfunction

  function automatic string sig_name(int sig);
    case (sig)
      S_IRQ:   return "irq_o";
      S_CAUSE: return "cause_o";
      S_RXWB:  return "rx_wb_o";
      default: return "tx_wb_o";
    endcase
  endfunction

  // Monitor: pops every expected item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        checks++;
        if (observe(sb[i].sig) != sb[i].exp) begin
          errors++;
          $display("FAIL %s %s cycle %0d: actual %0d expected %0d",
                   sb[i].req, sig_name(sb[i].sig), cyc,
                   observe(sb[i].sig), sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  // Driver tasks: each sets strobes at a negedge and returns the edge
  // that samples them; idle() drops them at the following negedge.
  task automatic idle();
    @(negedge clk);
    cause_i = '0; imm_i = 1'b0; mask_wr_i = 1'b0; clr_rd_i = 1'b0;
    tmr_load_i = '0; tmr_arm_i = '0;
  endtask

  task automatic load(int idx, int val);
    @(negedge clk);
    tmr_load_i[idx] = 1'b1;
    tmr_val_i = TW'(val);
    idle();
  endtask

  task automatic arm(logic [3:0] bits, output int e);
    @(negedge clk);
    tmr_arm_i = bits;
    e = cyc + 1;
  endtask

  task automatic set_mask(logic [NC-1:0] m, output int e);
    @(negedge clk);
    mask_wr_i = 1'b1; mask_val_i = m;
    e = cyc + 1;
  endtask

  task automatic clear(output int e);
    @(negedge clk);
    clr_rd_i = 1'b1;
    e = cyc + 1;
  endtask

  task automatic post(logic [NC-1:0] bits, logic imm, output int e);
    @(negedge clk);
    cause_i = bits; imm_i = imm;
    e = cyc + 1;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a, b, c, m, p;
    // R10 reset state
    wait_n(2);
    expect_at(cyc + 1, S_IRQ, 0, "R10");
    expect_at(cyc + 1, S_CAUSE, 0, "R10");
    expect_at(cyc + 1, S_RXWB, 0, "R10");
    expect_at(cyc + 1, S_TXWB, 0, "R10");
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);

    // R1 basic expiry, line raised with throttle off
    load(0, 3);
    set_mask(8'hFF, m); idle();
    arm(4'b0001, a);
    expect_at(a + 3*TK - 1, S_RXWB, 0, "R1");
    expect_at(a + 3*TK,     S_RXWB, 1, "R1");
    expect_at(a + 3*TK + 1, S_RXWB, 0, "R1");
    expect_at(a + 3*TK,     S_CAUSE, 0, "R1");
    expect_at(a + 3*TK + 1, S_CAUSE, 128, "R1");
    expect_at(a + 3*TK + 1, S_IRQ, 1, "R4");
    idle(); wait_n(3*TK + 4);
    // R8 clear on read
    clear(c);
    expect_at(c, S_CAUSE, 0, "R8");
    expect_at(c, S_IRQ, 0, "R8");
    idle(); wait_n(2);

    // R1 restart on re-arm
    arm(4'b0001, a); idle(); wait_n(2);
    arm(4'b0001, b);
    expect_at(a + 3*TK, S_RXWB, 0, "R1");
    expect_at(b + 3*TK, S_RXWB, 1, "R1");
    expect_at(b + 3*TK + 1, S_CAUSE, 128, "R1");
    idle(); wait_n(3*TK + 4);
    clear(c); idle(); wait_n(2);

    // R2 absolute timer ignores re-arm
    load(1, 3);
    arm(4'b0010, a);
    expect_at(a + 3*TK, S_RXWB, 1, "R2");
    expect_at(a + 3*TK + 1, S_CAUSE, 128, "R2");
    idle(); wait_n(2);
    arm(4'b0010, b);
    expect_at(b + 3*TK, S_RXWB, 0, "R2");
    idle(); wait_n(3*TK + 6);
    clear(c); idle(); wait_n(2);

    // R3 transmit absolute and idle timers
    load(2, 2); load(3, 2);
    arm(4'b1100, a);
    expect_at(a + 2*TK, S_TXWB, 1, "R3");
    expect_at(a + 2*TK + 1, S_TXWB, 0, "R3");
    expect_at(a + 2*TK + 1, S_CAUSE, 1, "R3");
    idle(); wait_n(1);
    arm(4'b1000, b);
    expect_at(b + 2*TK, S_TXWB, 1, "R3");
    idle(); wait_n(2*TK + 6);
    clear(c); idle(); wait_n(2);

    // R9 zero value disables a timer
    load(3, 0);
    arm(4'b1000, a);
    for (int k = 0; k <= 40; k++) expect_at(a + k, S_TXWB, 0, "R9");
    expect_at(a + 41, S_CAUSE, 0, "R9");
    idle(); wait_n(44);

    // R4 and R5 mask behaviour
    set_mask(8'h00, m); idle();
    post(8'h04, 1'b0, p);
    expect_at(p, S_CAUSE, 4, "R4");
    expect_at(p, S_IRQ, 0, "R4");
    idle(); wait_n(2);
    set_mask(8'h04, m);
    expect_at(m, S_IRQ, 1, "R5");
    idle(); wait_n(2);
    set_mask(8'h00, m);
    expect_at(m, S_IRQ, 0, "R5");
    idle();
    clear(c); idle(); wait_n(2);

    // R6 throttle holds a cause, then releases it
    load(4, 5);
    set_mask(8'hFF, m); idle();
    clear(c); idle();
    post(8'h02, 1'b0, p);
    expect_at(p, S_CAUSE, 2, "R6");
    expect_at(p, S_IRQ, 0, "R6");
    expect_at(c + 5*TK, S_IRQ, 0, "R6");
    expect_at(c + 5*TK + 1, S_IRQ, 1, "R6");
    idle(); wait_n(5*TK + 4);

    // R7 immediate post bypasses an active throttle; R8 restart
    clear(c);
    expect_at(c, S_IRQ, 0, "R8");
    idle();
    post(8'h08, 1'b1, p);
    expect_at(p, S_IRQ, 1, "R7");
    expect_at(p, S_CAUSE, 8, "R7");
    idle(); wait_n(5*TK + 4);
    clear(c); idle();

    wait_n(10);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    finish_run();
  end
endmodule